// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block is the front end of a numerically controlled oscillator. It turns tuning words into a lookup-table address. A host loads a center frequency, a frequency offset and a phase word over a 16-bit bus. That bus has a chip select and a write strobe, and a 2-bit address picks the target. The data lands in holding registers. Separate active-low enables then move the held words into the working registers. The enables are sampled on the system clock, so each one acts one cycle after it is driven.

On every enabled clock the block adds the center frequency and the offset. The offset can be gated to zero. The sum goes into a 32-bit phase accumulator, whose feedback can be zeroed so that it restarts from the current sum. The upper accumulator bits are added to a 16-bit phase term, and the result is registered as the table address. The phase term is either the bus-loaded phase word or a quadrant code that rotates the phase in 90-degree steps. A half-range mode holds the address MSB at zero, so addresses repeat every half turn.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A write happens on a rising edge of `bus_wr` only while `bus_cs_n` is low. Address 0 stores `bus_data` as a pending low half. Address 1 commits {`bus_data`, pending} as the held center frequency. Address 2 commits {`bus_data`, pending} as the held frequency offset. Address 3 stores `bus_data` as the held phase word.
- R2: Every control input is sampled on a rising `clk` edge and takes effect on the following edge. A phase-enable pulse therefore changes `rom_addr` three edges after it is driven, and not earlier.
- R3: The frequency sum is center plus offset, modulo 2^32. On each clock where the accumulator is enabled, the accumulator adds this sum to its previous value, modulo 2^32.
- R4: While `of_clr_n` is registered low, the offset contributes zero to the frequency sum. The offset register keeps its value and contributes again once the clear is released.
- R5: While `fb_load_n` is registered low, an enabled accumulator update stores only the frequency sum.
- R6: When the phase enable is registered low and `quad_sel` is low, the phase register loads the held phase word.
- R7: When the phase enable is registered low and `quad_sel` is high, the phase register loads a quadrant code. Its top two bits encode `quad_code` as 00→00 (0°), 01→01 (90°), 10→11 (270°) and 11→10 (180°). Its lower 14 bits are zero.
- R8: `rom_addr` is registered and equals the upper 16 accumulator bits plus the phase register, modulo 2^16.
- R9: When `half_sel` is registered high, bit 15 of `rom_addr` is 0 and the lower 15 bits are those of R8.
- R10: A synchronous active-high `rst` clears the accumulator, the working registers, `rom_addr` and the sampled controls. The sampled enables reset to their inactive state.
- R11: While the accumulator enable is registered high, the accumulator and `rom_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 16 | Host data bus |
| bus_addr | input | 2 | Holding-register select |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr | input | 1 | Write strobe, captures data on its rising edge |
| ph_en_n | input | 1 | Phase register load enable, active low |
| of_en_n | input | 1 | Offset register load enable, active low |
| cf_en_n | input | 1 | Center frequency load enable, active low |
| acc_en_n | input | 1 | Accumulator update enable, active low |
| of_clr_n | input | 1 | Zero the offset contribution, active low |
| fb_load_n | input | 1 | Zero the accumulator feedback, active low |
| half_sel | input | 1 | High: address MSB held at zero |
| quad_sel | input | 1 | High: phase register takes the quadrant code |
| quad_code | input | 2 | Quadrant modulation code |
| rom_addr | output | 16 | Lookup-table address |

## Verification
The bench runs a series of accumulation cases. Each case restarts the accumulator through the feedback-zero control, and sums and products are chosen so that both the frequency adder and the accumulator wrap. An accumulator that ignores the feedback zero would carry over the previous case's value, and a bad wrap would give a wrong upper word. The bench sets all four quadrant codes. A binary decoding would swap the 180° and 270° results. It checks that clearing the offset removes it for one case and that it returns unchanged in the next, which catches a clear that overwrites the register. It also counts the edges from an enable pulse to the output, which exposes a missing or extra pipeline stage. Writes with the chip select high must leave the output unchanged.

// File: rtl/nco_pc_pkg.sv
package nco_pc_pkg;

    localparam int BUS_W  = 16;
    localparam int SEL_W  = 2;

    // Holding-register selection on the host bus
    typedef enum logic [SEL_W-1:0] {
        SEL_STAGE  = 2'd0,
        SEL_CENTER = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_PHASE  = 2'd3
    } bus_sel_e;

    // Sampled controls, decoded to active high
    typedef struct packed {
        logic       ph_ld;
        logic       of_ld;
        logic       cf_ld;
        logic       acc_en;
        logic       of_zero;
        logic       fb_zero;
        logic       half_mode;
        logic       quad_sel;
        logic [1:0] quad;
    } ctrl_t;

    // Quadrant code to the two phase MSBs: 0, 90, 270, 180 degrees
    function automatic logic [1:0] quad_msbs(input logic [1:0] code);
        return {code[1], code[1] ^ code[0]};
    endfunction

endpackage

// File: rtl/nco_bus_regs.sv
module nco_bus_regs
    import nco_pc_pkg::*;
#(
    parameter int BUS_W = 16,
    localparam int FREQ_W = 2 * BUS_W
) (
    input  logic              wr_clk,
    input  logic              cs_n,
    input  logic [SEL_W-1:0]  addr,
    input  logic [BUS_W-1:0]  data,
    output logic [FREQ_W-1:0] center_hold,
    output logic [FREQ_W-1:0] offset_hold,
    output logic [BUS_W-1:0]  phase_hold
);

    logic [BUS_W-1:0] stage_lo;

    always_ff @(posedge wr_clk) begin
        if (!cs_n) begin
            unique case (bus_sel_e'(addr))
                SEL_STAGE:  stage_lo    <= data;
                SEL_CENTER: center_hold <= {data, stage_lo};
                SEL_OFFSET: offset_hold <= {data, stage_lo};
                SEL_PHASE:  phase_hold  <= data;
            endcase
        end
    end

endmodule

// File: rtl/nco_ctrl_sync.sv
module nco_ctrl_sync
    import nco_pc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ph_en_n,
    input  logic       of_en_n,
    input  logic       cf_en_n,
    input  logic       acc_en_n,
    input  logic       of_clr_n,
    input  logic       fb_load_n,
    input  logic       half_sel,
    input  logic       quad_sel,
    input  logic [1:0] quad_code,
    output ctrl_t      ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            ctrl <= '{ph_ld:     !ph_en_n,
                      of_ld:     !of_en_n,
                      cf_ld:     !cf_en_n,
                      acc_en:    !acc_en_n,
                      of_zero:   !of_clr_n,
                      fb_zero:   !fb_load_n,
                      half_mode: half_sel,
                      quad_sel:  quad_sel,
                      quad:      quad_code};
        end
    end

endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cf_ld,
    input  logic              of_ld,
    input  logic              acc_en,
    input  logic              of_zero,
    input  logic              fb_zero,
    input  logic [FREQ_W-1:0] center_hold,
    input  logic [FREQ_W-1:0] offset_hold,
    output logic [FREQ_W-1:0] freq_sum,
    output logic [FREQ_W-1:0] of_reg,
    output logic [FREQ_W-1:0] acc
);

    logic [FREQ_W-1:0] cf_reg;
    logic [FREQ_W-1:0] of_path;
    logic [FREQ_W-1:0] fb_path;

    always_comb begin
        of_path  = of_zero ? '0 : of_reg;
        freq_sum = cf_reg + of_path;
        fb_path  = fb_zero ? '0 : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cf_reg <= '0;
            of_reg <= '0;
            acc    <= '0;
        end else begin
            if (cf_ld)  cf_reg <= center_hold;
            if (of_ld)  of_reg <= offset_hold;
            if (acc_en) acc    <= fb_path + freq_sum;
        end
    end

endmodule

// File: rtl/nco_addr_gen.sv
module nco_addr_gen
    import nco_pc_pkg::*;
#(
    parameter int PH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ph_ld,
    input  logic            quad_sel,
    input  logic [1:0]      quad,
    input  logic            half_mode,
    input  logic [PH_W-1:0] phase_hold,
    input  logic [PH_W-1:0] acc_top,
    output logic [PH_W-1:0] ph_reg,
    output logic [PH_W-1:0] rom_addr
);

    localparam int LOW_W = PH_W - 2;

    logic [PH_W-1:0] ph_next;
    logic [PH_W-1:0] addr_sum;

    always_comb begin
        ph_next  = quad_sel ? {quad_msbs(quad), {LOW_W{1'b0}}} : phase_hold;
        addr_sum = acc_top + ph_reg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_reg   <= '0;
            rom_addr <= '0;
        end else begin
            if (ph_ld) ph_reg <= ph_next;
            rom_addr <= half_mode ? {1'b0, addr_sum[PH_W-2:0]} : addr_sum;
        end
    end

endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
    import nco_pc_pkg::*;
#(
    parameter int BUS_W = 16,
    localparam int FREQ_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_data,
    input  logic [1:0]       bus_addr,
    input  logic             bus_cs_n,
    input  logic             bus_wr,
    input  logic             ph_en_n,
    input  logic             of_en_n,
    input  logic             cf_en_n,
    input  logic             acc_en_n,
    input  logic             of_clr_n,
    input  logic             fb_load_n,
    input  logic             half_sel,
    input  logic             quad_sel,
    input  logic [1:0]       quad_code,
    output logic [BUS_W-1:0] rom_addr
);

    logic [FREQ_W-1:0] center_hold;
    logic [FREQ_W-1:0] offset_hold;
    logic [BUS_W-1:0]  phase_hold;
    ctrl_t             ctrl_q;
    logic [FREQ_W-1:0] freq_sum;
    logic [FREQ_W-1:0] of_q;
    logic [FREQ_W-1:0] acc_q;
    logic [BUS_W-1:0]  ph_q;

    nco_bus_regs #(.BUS_W(BUS_W)) u_bus (
        .wr_clk      (bus_wr),
        .cs_n        (bus_cs_n),
        .addr        (bus_addr),
        .data        (bus_data),
        .center_hold (center_hold),
        .offset_hold (offset_hold),
        .phase_hold  (phase_hold)
    );

    nco_ctrl_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .ph_en_n   (ph_en_n),
        .of_en_n   (of_en_n),
        .cf_en_n   (cf_en_n),
        .acc_en_n  (acc_en_n),
        .of_clr_n  (of_clr_n),
        .fb_load_n (fb_load_n),
        .half_sel  (half_sel),
        .quad_sel  (quad_sel),
        .quad_code (quad_code),
        .ctrl      (ctrl_q)
    );

    nco_phase_accum #(.FREQ_W(FREQ_W)) u_accum (
        .clk         (clk),
        .rst         (rst),
        .cf_ld       (ctrl_q.cf_ld),
        .of_ld       (ctrl_q.of_ld),
        .acc_en      (ctrl_q.acc_en),
        .of_zero     (ctrl_q.of_zero),
        .fb_zero     (ctrl_q.fb_zero),
        .center_hold (center_hold),
        .offset_hold (offset_hold),
        .freq_sum    (freq_sum),
        .of_reg      (of_q),
        .acc         (acc_q)
    );

    nco_addr_gen #(.PH_W(BUS_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .ph_ld      (ctrl_q.ph_ld),
        .quad_sel   (ctrl_q.quad_sel),
        .quad       (ctrl_q.quad),
        .half_mode  (ctrl_q.half_mode),
        .phase_hold (phase_hold),
        .acc_top    (acc_q[FREQ_W-1 -: BUS_W]),
        .ph_reg     (ph_q),
        .rom_addr   (rom_addr)
    );

endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk #(
    parameter int BUS_W = 16,
    localparam int FREQ_W = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              ph_ld,
    input logic              of_ld,
    input logic              acc_en,
    input logic              fb_zero,
    input logic              half_mode,
    input logic              quad_sel,
    input logic [FREQ_W-1:0] freq_sum,
    input logic [FREQ_W-1:0] of_reg,
    input logic [FREQ_W-1:0] acc,
    input logic [BUS_W-1:0]  ph_reg,
    input logic [BUS_W-1:0]  rom_addr
);

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rom_addr == '0 && acc == '0));

    assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(acc));

    assert_fb_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && fb_zero) |=> (acc == $past(freq_sum)));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
        !of_ld |=> $stable(of_reg));

    assert_quad_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (ph_ld && quad_sel) |=> (ph_reg[BUS_W-3:0] == '0));

    assert_half_msb_R9: assert property (@(posedge clk) disable iff (rst)
        half_mode |=> !rom_addr[BUS_W-1]);

endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ph_ld     (ctrl_q.ph_ld),
    .of_ld     (ctrl_q.of_ld),
    .acc_en    (ctrl_q.acc_en),
    .fb_zero   (ctrl_q.fb_zero),
    .half_mode (ctrl_q.half_mode),
    .quad_sel  (ctrl_q.quad_sel),
    .freq_sum  (freq_sum),
    .of_reg    (of_q),
    .acc       (acc_q),
    .ph_reg    (ph_q),
    .rom_addr  (rom_addr)
);

// File: tb/test_nco_phase_ctrl.sv
module test_nco_phase_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_data = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic        ph_en_n = 1'b1;
    logic        of_en_n = 1'b1;
    logic        cf_en_n = 1'b1;
    logic        acc_en_n = 1'b1;
    logic        of_clr_n = 1'b1;
    logic        fb_load_n = 1'b1;
    logic        half_sel = 1'b0;
    logic        quad_sel = 1'b0;
    logic [1:0]  quad_code = '0;
    logic [15:0] rom_addr;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    nco_phase_ctrl i_nco_phase_ctrl (
        .clk(clk), .rst(rst), .bus_data(bus_data), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_wr(bus_wr), .ph_en_n(ph_en_n),
        .of_en_n(of_en_n), .cf_en_n(cf_en_n), .acc_en_n(acc_en_n),
        .of_clr_n(of_clr_n), .fb_load_n(fb_load_n), .half_sel(half_sel),
        .quad_sel(quad_sel), .quad_code(quad_code), .rom_addr(rom_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s rom_addr actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic cs);
        bus_addr = a;
        bus_data = d;
        bus_cs_n = cs;
        #3 bus_wr = 1'b1;
        #3 bus_wr = 1'b0;
        #2 bus_cs_n = 1'b1;
    endtask

    function automatic logic [1:0] quad_top(input logic [1:0] c);
        case (c)
            2'b00:   return 2'b00;
            2'b01:   return 2'b01;
            2'b10:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // One accumulation case: load registers, restart accumulator, run n updates
    task automatic run_case(input string req, input logic [31:0] f, input logic [31:0] o,
                            input logic [15:0] p, input int n, input bit clr, input bit half,
                            input bit qsel, input logic [1:0] qc, input bit wr);
        logic [31:0] s;
        logic [31:0] a;
        logic [15:0] pe;
        logic [15:0] exp;
        if (wr) begin
            bus_write(2'd0, f[15:0], 1'b0);
            bus_write(2'd1, f[31:16], 1'b0);
            bus_write(2'd0, o[15:0], 1'b0);
            bus_write(2'd2, o[31:16], 1'b0);
            bus_write(2'd3, p, 1'b0);
        end
        @(negedge clk);
        of_clr_n = !clr; half_sel = half; quad_sel = qsel; quad_code = qc;
        cf_en_n = 1'b0; of_en_n = 1'b0; ph_en_n = 1'b0;
        @(negedge clk);
        cf_en_n = 1'b1; of_en_n = 1'b1; ph_en_n = 1'b1;
        repeat (2) @(negedge clk);
        acc_en_n = 1'b0; fb_load_n = 1'b0;
        @(negedge clk);
        fb_load_n = 1'b1;
        repeat (n - 1) @(negedge clk);
        acc_en_n = 1'b1;
        repeat (4) @(negedge clk);
        s = f + (clr ? 32'd0 : o);
        a = s * 32'(n);
        pe = qsel ? {quad_top(qc), 14'd0} : p;
        exp = a[31:16] + pe;
        if (half) exp[15] = 1'b0;
        check(req, rom_addr, exp);
        repeat (6) @(negedge clk);
        check({req, " hold R11"}, rom_addr, exp);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset clears output", rom_addr, 16'h0000);

        // R2 / R8: latency from a phase-enable pulse
        bus_write(2'd3, 16'h0ABC, 1'b0);
        @(negedge clk);
        ph_en_n = 1'b0;
        @(negedge clk);
        ph_en_n = 1'b1;
        @(negedge clk);
        check("R2 enable not yet effective", rom_addr, 16'h0000);
        @(negedge clk);
        check("R8 R6 phase word at output", rom_addr, 16'h0ABC);

        run_case("R3 R5 basic accumulate", 32'h0001_0000, 32'h0000_8000, 16'h0100, 5, 0, 0, 0, 2'd0, 1);
        run_case("R3 accumulator wrap", 32'h3000_0001, 32'h1234_5678, 16'hF000, 9, 0, 0, 0, 2'd0, 1);
        run_case("R4 offset cleared", 32'h3000_0001, 32'h1234_5678, 16'hF000, 6, 1, 0, 0, 2'd0, 0);
        run_case("R4 offset retained", 32'h3000_0001, 32'h1234_5678, 16'hF000, 6, 0, 0, 0, 2'd0, 0);
        run_case("R9 half range", 32'h9ABC_0000, 32'h0100_0000, 16'h1234, 3, 0, 1, 0, 2'd0, 1);
        for (int c = 0; c < 4; c++) begin
            run_case("R7 quadrant code", 32'h0123_0000, 32'h0, 16'h3FFF, 1, 0, 0, 1, 2'(c), 1);
        end
        run_case("R7 R9 quadrant half range", 32'h0123_0000, 32'h0, 16'h3FFF, 1, 0, 1, 1, 2'd2, 0);

        // R1: writes with chip select high are ignored
        bus_write(2'd0, 16'hFFFF, 1'b1);
        bus_write(2'd1, 16'hFFFF, 1'b1);
        bus_write(2'd3, 16'h7777, 1'b1);
        run_case("R1 chip select ignored", 32'h0123_0000, 32'h0, 16'h3FFF, 2, 0, 0, 0, 2'd0, 0);

        run_case("R3 frequency sum wrap", 32'hFFFF_FFF0, 32'h0000_0020, 16'h0000, 4096, 0, 0, 0, 2'd0, 1);
        run_case("R1 R6 staged halves", 32'h8001_7FFF, 32'h0002_8001, 16'h8000, 7, 0, 0, 0, 2'd0, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule